// File: doc/BRIEF.md
# PLL Configuration Register Sequencer

This block brings a PLL up in hardware through two 32-bit control registers, called here the primary control word (`ctl0`) and the auxiliary control word (`ctl1`). A single-cycle `start` pulse carries a requested pre-divider, multiplier and post-divider. On an accepted request the sequencer takes a snapshot of the present contents of both registers from the read ports. It derives a 12-bit loop-bandwidth value from the multiplier. It then issues a fixed series of eight register writes. Two timed waits sit inside the series: one holds the PLL in reset, and the other lets the loop settle while bypass stays on.

Every write is a read-modify-write on an internal shadow of the register. Only the field that the step owns changes, and every other bit keeps its value. The shadow is presented on `ctl0`/`ctl1`, and the write strobe of the matching register pulses for one cycle. The reset-hold time is a parameter counted in system-clock cycles. The settle time is computed at start as the requested pre-divider times 500 reference-clock periods, with `REF_RATIO` system cycles per reference cycle.

Top module: `pll_cfg_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `ctl0_we` and `ctl1_we` are 0, and `ctl0` and `ctl1` are 0.
- R2: An accepted `start` copies `ctl0_rd`/`ctl1_rd` into the register images in the next cycle and raises `busy`. The read ports are then ignored until the sequence finishes.
- R3: An accepted request produces exactly eight single-cycle strobes, never two in one cycle, in this order: `ctl1` bit 6 set (saturation enable), `ctl0` bit 23 set (bypass on), `ctl0` divider load, `ctl1` upper bandwidth bits, `ctl1` bit 14 set (PLL reset on), `ctl1` bit 13 set (PLL output selected), `ctl1` bit 14 cleared, and `ctl0` bit 23 cleared. The first five writes come on consecutive cycles.
- R4: The divider load puts pre-divider−1 in `ctl0[5:0]`, multiplier−1 in `ctl0[18:6]`, and bandwidth bits [7:0] in `ctl0[31:24]`.
- R5: The bandwidth value is (multiplier >> 1) − 1 as 12 bits. Its bits [11:8] go into `ctl1[3:0]`.
- R6: The bit-14 set write is followed by the bit-13 write RST_CYC+1 cycles later, and the bit-14 clear write comes one cycle after that.
- R7: The bypass-clear write comes prediv×500×REF_RATIO+1 cycles after the bit-14 clear write.
- R8: Bits outside the field being written keep their snapshot values, including the post-divider field `ctl0[22:19]`.
- R9: A `start` while `busy` is high is ignored and does not change the running sequence.
- R10: `done` is high for exactly one cycle, the cycle of the bypass-clear strobe. `busy` is high from the cycle after the start until that cycle and is low in it.
- R11: A request with pre-divider outside 1..64, multiplier outside 2..8192 or post-divider outside 1..16 gives a one-cycle `err` pulse. No strobe follows, the images stay unchanged, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse |
| req_prediv | input | 7 | Requested pre-divider (1..64) |
| req_mult | input | 14 | Requested multiplier (2..8192) |
| req_postdiv | input | 5 | Requested post-divider (1..16), range-checked only |
| ctl0_rd | input | 32 | Current contents of control word 0 |
| ctl1_rd | input | 32 | Current contents of control word 1 |
| ctl0 | output | 32 | Image to write to control word 0 |
| ctl1 | output | 32 | Image to write to control word 1 |
| ctl0_we | output | 1 | Write strobe for control word 0 |
| ctl1_we | output | 1 | Write strobe for control word 1 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
The assertions take for granted that `start` is a pulse and that the snapshot taken at start is the only source of register contents. They check the post-divider field only across strobes, so changes at the snapshot edge do not trip them. The bench keeps `start` to one cycle and drives new read-port values only while the block is busy or idle-rejected. With that stimulus, a strobe is the only way an image can change after capture. Injected mid-run starts use values that differ from the running request, so any leak shows up in the recorded write images.

// File: rtl/pll_cfg_sequencer.sv
module pll_cfg_sequencer #(
  parameter int unsigned RST_CYC   = 5000,
  parameter int unsigned REF_RATIO = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [6:0]  req_prediv,
  input  logic [13:0] req_mult,
  input  logic [4:0]  req_postdiv,
  input  logic [31:0] ctl0_rd,
  input  logic [31:0] ctl1_rd,
  output logic [31:0] ctl0,
  output logic [31:0] ctl1,
  output logic        ctl0_we,
  output logic        ctl1_we,
  output logic        busy,
  output logic        done,
  output logic        err
);
  localparam int unsigned LOCK_UNIT = REF_RATIO * 500;

  typedef enum logic [3:0] {
    S_IDLE, S_SAT, S_BYP, S_DIV, S_BWH, S_RST, S_HOLD, S_SEL, S_REL, S_LOCK, S_UNBYP
  } st_t;

  st_t         state;
  logic [31:0] cnt, lock_tgt;
  logic [5:0]  pd_m1;
  logic [12:0] ml_m1;
  logic [11:0] bw;
  logic        req_ok;

  assign req_ok = (req_prediv != 7'd0) && (req_prediv <= 7'd64) &&
                  (req_mult >= 14'd2) && (req_mult <= 14'd8192) &&
                  (req_postdiv != 5'd0) && (req_postdiv <= 5'd16);
  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      lock_tgt <= '0;
      pd_m1    <= '0;
      ml_m1    <= '0;
      bw       <= '0;
      ctl0     <= '0;
      ctl1     <= '0;
      ctl0_we  <= 1'b0;
      ctl1_we  <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      ctl0_we <= 1'b0;
      ctl1_we <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          if (req_ok) begin
            ctl0     <= ctl0_rd;
            ctl1     <= ctl1_rd;
            pd_m1    <= 6'(req_prediv - 7'd1);
            ml_m1    <= 13'(req_mult - 14'd1);
            bw       <= req_mult[12:1] - 12'd1;
            lock_tgt <= 32'(req_prediv) * LOCK_UNIT;
            state    <= S_SAT;
          end else begin
            err <= 1'b1;
          end
        end
        S_SAT: begin
          ctl1[6] <= 1'b1; ctl1_we <= 1'b1; state <= S_BYP;
        end
        S_BYP: begin
          ctl0[23] <= 1'b1; ctl0_we <= 1'b1; state <= S_DIV;
        end
        S_DIV: begin
          ctl0[5:0]   <= pd_m1;
          ctl0[18:6]  <= ml_m1;
          ctl0[31:24] <= bw[7:0];
          ctl0_we     <= 1'b1;
          state       <= S_BWH;
        end
        S_BWH: begin
          ctl1[3:0] <= bw[11:8]; ctl1_we <= 1'b1; state <= S_RST;
        end
        S_RST: begin
          ctl1[14] <= 1'b1; ctl1_we <= 1'b1; cnt <= '0; state <= S_HOLD;
        end
        S_HOLD: begin
          if (cnt == 32'(RST_CYC - 1)) state <= S_SEL;
          else cnt <= cnt + 32'd1;
        end
        S_SEL: begin
          ctl1[13] <= 1'b1; ctl1_we <= 1'b1; state <= S_REL;
        end
        S_REL: begin
          ctl1[14] <= 1'b0; ctl1_we <= 1'b1; cnt <= '0; state <= S_LOCK;
        end
        S_LOCK: begin
          if (cnt == lock_tgt - 32'd1) state <= S_UNBYP;
          else cnt <= cnt + 32'd1;
        end
        S_UNBYP: begin
          ctl0[23] <= 1'b0; ctl0_we <= 1'b1; done <= 1'b1; state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_cfg_sequencer_chk.sv
module pll_cfg_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctl0,
  input logic [31:0] ctl1,
  input logic        ctl0_we,
  input logic        ctl1_we,
  input logic        busy,
  input logic        done,
  input logic        err
);
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl0_we && ctl1_we));

  p_no_idle_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl0_we || ctl1_we) |-> (busy || done));

  p_postdiv_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl0_we |-> $stable(ctl0[22:19]));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && ctl0_we));

  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!ctl0_we && !ctl1_we && !busy));

  p_release_after_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl1_we && $fell(ctl1[14])) |-> ctl1[13]);

  p_unbypass_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl0_we && $fell(ctl0[23])) |-> (done && !ctl1[14]));
endmodule

bind pll_cfg_sequencer pll_cfg_sequencer_chk u_chk (.*);

// File: tb/tb_pll_cfg_sequencer.sv
`timescale 1ns/1ps
module tb_pll_cfg_sequencer;
  localparam int unsigned RST = 6;
  localparam int unsigned RR  = 1;

  logic clk = 0, rst_n = 0, start = 0;
  logic [6:0] req_prediv = 0;
  logic [13:0] req_mult = 0;
  logic [4:0] req_postdiv = 0;
  logic [31:0] ctl0_rd = 0, ctl1_rd = 0;
  logic [31:0] ctl0, ctl1;
  logic ctl0_we, ctl1_we, busy, done, err;

  int checks = 0, failures = 0;

  pll_cfg_sequencer #(.RST_CYC(RST), .REF_RATIO(RR)) dut (.*);

  always #5 clk = ~clk;

  localparam logic [6:0]  V_PD [4] = '{7'd1, 7'd3, 7'd2, 7'd64};
  localparam logic [13:0] V_ML [4] = '{14'd2, 14'd3, 14'd100, 14'd8192};
  localparam logic [4:0]  V_PO [4] = '{5'd1, 5'd16, 5'd7, 5'd4};
  localparam logic [31:0] V_C0 [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h5A3C_96E1, 32'h0123_4567};
  localparam logic [31:0] V_C1 [4] = '{32'h0000_0000, 32'hFFFF_BFFF, 32'hA5C3_1E0F, 32'h89AB_CDEF};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  int          wr_n;
  int          wr_t [16];
  bit          wr_r [16];
  logic [31:0] wr_v [16];

  task automatic run_req(input logic [6:0] pd, input logic [13:0] ml, input logic [4:0] po,
                         input logic [31:0] c0, input logic [31:0] c1, input bit inject);
    logic [11:0] bw;
    logic [31:0] e_v [8];
    bit          e_r [8];
    int          e_t [8];
    int          cyc;
    bit          fin;
    bw = ml[12:1] - 12'd1;
    e_r = '{1, 0, 0, 1, 1, 1, 1, 0};
    e_v[0] = c1 | 32'h40;
    e_v[1] = c0 | 32'h0080_0000;
    e_v[2] = {bw[7:0], e_v[1][23:19], 13'(ml - 14'd1), 6'(pd - 7'd1)};
    e_v[3] = {e_v[0][31:4], bw[11:8]};
    e_v[4] = e_v[3] | 32'h4000;
    e_v[5] = e_v[4] | 32'h2000;
    e_v[6] = e_v[5] & ~32'h4000;
    e_v[7] = e_v[2] & ~32'h0080_0000;
    e_t = '{0, 1, 2, 3, 4, RST + 5, RST + 6, RST + 7 + int'(pd) * 500 * RR};

    @(negedge clk);
    req_prediv = pd; req_mult = ml; req_postdiv = po; ctl0_rd = c0; ctl1_rd = c1; start = 1;
    @(negedge clk);
    start = 0; ctl0_rd = ~c0; ctl1_rd = ~c1;
    chk(busy === 1'b1, "R2 busy after start", {31'd0, busy}, 32'd1);
    chk(ctl0 === c0, "R2 ctl0 snapshot", ctl0, c0);
    chk(ctl1 === c1, "R2 ctl1 snapshot", ctl1, c1);
    wr_n = 0; cyc = 0; fin = 0;
    while (!fin && cyc < 80000) begin
      @(negedge clk);
      if (inject && cyc == 20) begin
        start = 1; req_prediv = 7'd5; req_mult = 14'd50; ctl0_rd = 32'hDEAD_BEEF; ctl1_rd = 32'h0BAD_F00D;
      end else start = 0;
      if (ctl0_we && ctl1_we) chk(0, "R3 two strobes", 32'd3, 32'd1);
      if ((ctl0_we || ctl1_we) && wr_n < 16) begin
        wr_t[wr_n] = cyc; wr_r[wr_n] = ctl1_we; wr_v[wr_n] = ctl1_we ? ctl1 : ctl0; wr_n++;
      end
      if (done) begin
        fin = 1;
        chk(busy === 1'b0, "R10 busy low with done", {31'd0, busy}, 32'd0);
      end else if (!busy) chk(0, "R10 busy dropped early", 32'd0, 32'd1);
      cyc++;
    end
    chk(fin, "R10 done seen", {31'd0, fin}, 32'd1);
    @(negedge clk);
    chk(done === 1'b0, "R10 done one cycle", {31'd0, done}, 32'd0);
    chk(!ctl0_we && !ctl1_we, "R3 no extra strobe", {30'd0, ctl0_we, ctl1_we}, 32'd0);
    chk(wr_n == 8, "R3 write count", wr_n, 8);
    if (wr_n == 8) begin
      for (int k = 0; k < 8; k++) begin
        chk(wr_r[k] == e_r[k], $sformatf("R3 write %0d target", k), {31'd0, wr_r[k]}, {31'd0, e_r[k]});
        chk(wr_v[k] === e_v[k], $sformatf("R4 R5 R8 write %0d image", k), wr_v[k], e_v[k]);
        chk(wr_t[k] - wr_t[0] == e_t[k], k == 7 ? "R7 settle timing" : $sformatf("R6 R3 write %0d timing", k),
            wr_t[k] - wr_t[0], e_t[k]);
      end
      chk(wr_v[2][22:19] == c0[22:19], "R8 postdiv kept", {28'd0, wr_v[2][22:19]}, {28'd0, c0[22:19]});
    end
  endtask

  task automatic bad_req(input logic [6:0] pd, input logic [13:0] ml, input logic [4:0] po, input string tag);
    logic [31:0] p0, p1;
    p0 = ctl0; p1 = ctl1;
    @(negedge clk);
    req_prediv = pd; req_mult = ml; req_postdiv = po; ctl0_rd = 32'hCAFE_0001; ctl1_rd = 32'hCAFE_0002; start = 1;
    @(negedge clk);
    start = 0;
    chk(err === 1'b1, {"R11 err pulse ", tag}, {31'd0, err}, 32'd1);
    chk(!busy && !ctl0_we && !ctl1_we, {"R11 no activity ", tag}, {29'd0, busy, ctl0_we, ctl1_we}, 32'd0);
    chk(ctl0 === p0 && ctl1 === p1, {"R11 images kept ", tag}, ctl0 ^ p0 ^ ctl1 ^ p1, 32'd0);
    @(negedge clk);
    chk(err === 1'b0 && !ctl0_we && !ctl1_we, {"R11 err single ", tag}, {29'd0, err, ctl0_we, ctl1_we}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !ctl0_we && !ctl1_we, "R1 reset outputs",
        {27'd0, busy, done, err, ctl0_we, ctl1_we}, 32'd0);
    chk(ctl0 === 32'd0 && ctl1 === 32'd0, "R1 reset images", ctl0 | ctl1, 32'd0);
    rst_n = 1;
    for (int i = 0; i < 4; i++) run_req(V_PD[i], V_ML[i], V_PO[i], V_C0[i], V_C1[i], 0);
    run_req(7'd2, 14'd100, 5'd7, 32'h1357_9BDF, 32'h2468_ACE0, 1); // R9 mid-run start ignored
    bad_req(7'd0,  14'd10,   5'd1,  "prediv0");
    bad_req(7'd65, 14'd10,   5'd1,  "prediv65");
    bad_req(7'd4,  14'd1,    5'd1,  "mult1");
    bad_req(7'd4,  14'd8193, 5'd1,  "mult8193");
    bad_req(7'd4,  14'd10,   5'd0,  "postdiv0");
    bad_req(7'd4,  14'd10,   5'd17, "postdiv17");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule